// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block turns 4-bit media-independent transmit nibbles into the 125 Mbit/s three-level line symbol stream that feeds an analog driver. It runs on the 125 MHz symbol clock. It derives a 25 MHz nibble clock `tx_clk_o` for the MAC and samples the nibble, the enable and the error input once per five symbol cycles.

A frame is wrapped in start and end delimiters, with data carried as 4B5B code groups. An error request replaces the nibble's code with a fixed error group. Between frames the block sends idle groups. Every bit is XORed with a free-running 11-bit scrambler key. The result is MLT3 coded into a 2-bit signed level.

Nothing runs until the symbol clock synthesizer reports lock. When lock drops, the block returns to its power-on state. A loopback input silences the line output without stopping the internal pipeline.

Top module: `fe_sym_enc`

## Requirements
- R1: While locked, `tx_clk_o` repeats a 5-cycle pattern of two high cycles and three low cycles. The nibble inputs are sampled at the clock edge where `tx_clk_o` rises. While unlocked or in reset, `tx_clk_o` is low.
- R2: While `lock_i` is low, or in reset, `mlt3_o` is 2'b00 and `tx_clk_o` is low. Each edge with `lock_i` low returns the framing state, the serializer, the scrambler seed and the MLT3 state to their reset values.
- R3: When no frame is in progress, the raw code group sent is 11111, and it is scrambled like any other group.
- R4: A frame starts at the first sample with `tx_en_i` high. That nibble is replaced by J (11000) and the next nibble by K (10001), whatever their data, error or enable values.
- R5: From the third nibble of a frame on, each nibble d is sent as its 4B5B code (0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101). Every code group is sent leftmost bit first, where `txd_i[3]` is the leftmost bit of the nibble.
- R6: A data-phase nibble sampled with both `tx_en_i` and `tx_er_i` high is sent as 00100 in place of its 4B5B code.
- R7: The first sample with `tx_en_i` low after the data phase sends T (01101), and the next sample sends R (00111). The nibble sampled during R is ignored, even if `tx_en_i` is high, and idle or a new J follows.
- R8: The first bit of a code group reaches the MLT3 state 8 symbol cycles after the edge that sampled its nibble. The same delay of 8 applies to every group.
- R9: The scrambler is an 11-bit shift register with key bit s[10] XOR s[8] (x^11 + x^9 + 1). The key is shifted into s[0] on every locked cycle, and the register is loaded with the nonzero `SEED` while unlocked. The line bit is the raw bit XOR key.
- R10: The MLT3 state starts at level 0. On each line bit of 1 it steps through 0, +1, 0, -1 in turn, and it holds on a 0. `mlt3_o` codes the levels as 00 for 0, 01 for +1 and 11 for -1.
- R11: While `loopback_i` is high, `mlt3_o` is 2'b00. The pipeline keeps running, so the output resumes exactly where it would have been.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz symbol clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Synthesizer lock; low holds the block inactive |
| loopback_i | input | 1 | Loopback; silences the line output |
| tx_en_i | input | 1 | Transmit enable from MAC |
| tx_er_i | input | 1 | Transmit error request from MAC |
| txd_i | input | 4 | Transmit nibble from MAC |
| tx_clk_o | output | 1 | 25 MHz nibble clock to MAC |
| mlt3_o | output | 2 | Signed line level: 00 zero, 01 plus, 11 minus |

## Verification
A nibble sampled at locked edge n (every n divisible by 5) contributes its five bits to the MLT3 state at edges n+8 through n+12. `tx_clk_o` after edge n is due high exactly when n mod 5 is 0 or 1. The bench keeps its own locked-edge counter and a 16-slot bit schedule filled from its own framing model. It compares both outputs one nanosecond after every rising edge. Inputs change only on falling edges, right after a sampling edge, so each nibble is stable for the full period before its sample.

// File: rtl/fe_sym_pkg.sv
package fe_sym_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  typedef logic [CG_W-1:0] cg_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;
  localparam cg_t CG_ERR  = 5'b00100;

  localparam logic [1:0] LV_ZERO = 2'b00;
  localparam logic [1:0] LV_POS  = 2'b01;
  localparam logic [1:0] LV_NEG  = 2'b11;

  typedef enum logic [1:0] {FS_IDLE, FS_K, FS_DATA, FS_R} frm_st_e;

  function automatic cg_t enc_4b5b(input logic [NIB_W-1:0] nib);
    cg_t c;
    case (nib)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fe_sym_frame.sv
module fe_sym_frame
  import fe_sym_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic             load_i,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  input  logic [NIB_W-1:0] txd_i,
  output cg_t              cg_o
);
  logic             en_q, er_q;
  logic [NIB_W-1:0] d_q;
  frm_st_e          st_q, st_d;
  cg_t              cg_q, cg_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      er_q <= 1'b0;
      d_q  <= '0;
      st_q <= FS_IDLE;
      cg_q <= CG_IDLE;
    end else if (clr_i) begin
      en_q <= 1'b0;
      er_q <= 1'b0;
      d_q  <= '0;
      st_q <= FS_IDLE;
      cg_q <= CG_IDLE;
    end else begin
      if (smp_i) begin
        en_q <= tx_en_i;
        er_q <= tx_er_i;
        d_q  <= txd_i;
      end
      if (load_i) begin
        st_q <= st_d;
        cg_q <= cg_d;
      end
    end
  end

  // delimiters take precedence over data and error
  always_comb begin
    st_d = st_q;
    cg_d = CG_IDLE;
    case (st_q)
      FS_IDLE: if (en_q) begin
        cg_d = CG_J;
        st_d = FS_K;
      end
      FS_K: begin
        cg_d = CG_K;
        st_d = FS_DATA;
      end
      FS_DATA: begin
        if (!en_q) begin
          cg_d = CG_T;
          st_d = FS_R;
        end else if (er_q) begin
          cg_d = CG_ERR;
        end else begin
          cg_d = enc_4b5b(d_q);
        end
      end
      default: begin
        cg_d = CG_R;
        st_d = FS_IDLE;
      end
    endcase
  end

  assign cg_o = cg_q;
endmodule

// File: rtl/fe_sym_serial.sv
module fe_sym_serial
  import fe_sym_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic load_i,
  input  cg_t  cg_i,
  output logic bit_o
);
  cg_t sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= CG_IDLE;
    else if (clr_i)    sh_q <= CG_IDLE;
    else if (adv_i) begin
      if (load_i) sh_q <= cg_i;
      else        sh_q <= {sh_q[CG_W-2:0], 1'b1};
    end
  end

  assign bit_o = sh_q[CG_W-1];
endmodule

// File: rtl/fe_sym_scram.sv
module fe_sym_scram #(
  parameter int          LFSR_W = 11,
  parameter int          TAP    = 9,
  parameter logic [10:0] SEED   = 11'h5A3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic              key_o,
  output logic [LFSR_W-1:0] state_o
);
  localparam logic [LFSR_W-1:0] SEED_W = LFSR_W'(SEED);
  logic [LFSR_W-1:0] lfsr_q;

  assign key_o = lfsr_q[LFSR_W-1] ^ lfsr_q[TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED_W;
    else if (clr_i)  lfsr_q <= SEED_W;
    else if (adv_i)  lfsr_q <= {lfsr_q[LFSR_W-2:0], key_o};
  end

  assign state_o = lfsr_q;
endmodule

// File: rtl/fe_sym_mlt3.sv
module fe_sym_mlt3
  import fe_sym_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       adv_i,
  input  logic       bit_i,
  output logic [1:0] st_o,
  output logic [1:0] level_o
);
  logic [1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              st_q <= 2'd0;
    else if (clr_i)           st_q <= 2'd0;
    else if (adv_i && bit_i)  st_q <= st_q + 2'd1;
  end

  always_comb begin
    case (st_q)
      2'd1:    level_o = LV_POS;
      2'd3:    level_o = LV_NEG;
      default: level_o = LV_ZERO;
    endcase
  end

  assign st_o = st_q;
endmodule

// File: rtl/fe_sym_enc.sv
module fe_sym_enc
  import fe_sym_pkg::*;
#(
  parameter logic [10:0] SEED = 11'h5A3,
  parameter int          LAT  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             loopback_i,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  input  logic [NIB_W-1:0] txd_i,
  output logic             tx_clk_o,
  output logic [1:0]       mlt3_o
);
  localparam int PH_N    = CG_W;
  localparam int PH_W    = $clog2(PH_N);
  localparam int SMP_PH  = PH_N - 1;
  // serializer load phase set so the first bit hits MLT3 LAT edges after sampling
  localparam int LOAD_PH = (SMP_PH + LAT - 1) % PH_N;

  logic [PH_W-1:0] ph_q;
  logic            run_q;
  logic            clr, smp, load;
  cg_t             cg;
  logic            raw_bit, key, line_bit;
  logic [10:0]     lfsr_st;
  logic [1:0]      mst, level;

  assign clr  = !lock_i;
  assign smp  = lock_i && (ph_q == PH_W'(SMP_PH));
  assign load = lock_i && (ph_q == PH_W'(LOAD_PH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= lock_i;
      if (!lock_i)                        ph_q <= '0;
      else if (ph_q == PH_W'(PH_N - 1))   ph_q <= '0;
      else                                ph_q <= ph_q + 1'b1;
    end
  end

  assign tx_clk_o = run_q && (ph_q < PH_W'(2));

  fe_sym_frame u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .smp_i   (smp),
    .load_i  (load),
    .tx_en_i (tx_en_i),
    .tx_er_i (tx_er_i),
    .txd_i   (txd_i),
    .cg_o    (cg)
  );

  fe_sym_serial u_serial (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (lock_i),
    .load_i (load),
    .cg_i   (cg),
    .bit_o  (raw_bit)
  );

  fe_sym_scram #(.LFSR_W(11), .TAP(9), .SEED(SEED)) u_scram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .adv_i   (lock_i),
    .key_o   (key),
    .state_o (lfsr_st)
  );

  assign line_bit = raw_bit ^ key;

  fe_sym_mlt3 u_mlt3 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .adv_i   (lock_i),
    .bit_i   (line_bit),
    .st_o    (mst),
    .level_o (level)
  );

  assign mlt3_o = loopback_i ? LV_ZERO : level;
endmodule

// File: rtl/fe_sym_enc_chk.sv
module fe_sym_enc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lock_i,
  input logic        loopback_i,
  input logic        tx_clk_o,
  input logic [1:0]  mlt3_o,
  input logic [2:0]  ph_q,
  input logic [1:0]  mst,
  input logic [10:0] lfsr_st
);
  a_r2_unlock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> (mlt3_o == 2'b00 && !tx_clk_o && ph_q == 3'd0));

  a_r11_loop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_i |-> mlt3_o == 2'b00);

  a_r10_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> (mst == $past(mst) || mst == 2'($past(mst) + 2'd1)));

  a_r9_lfsr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_st != 11'd0);

  a_r1_clk_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && ph_q == 3'd4) |=> tx_clk_o);
endmodule

bind fe_sym_enc fe_sym_enc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lock_i     (lock_i),
  .loopback_i (loopback_i),
  .tx_clk_o   (tx_clk_o),
  .mlt3_o     (mlt3_o),
  .ph_q       (ph_q),
  .mst        (mst),
  .lfsr_st    (lfsr_st)
);

// File: tb/fe_sym_enc_test.sv
`timescale 1ns/1ps
module fe_sym_enc_test;
  localparam logic [10:0] SEED = 11'h5A3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lock_i = 1'b0;
  logic       loopback_i = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       tx_er_i = 1'b0;
  logic [3:0] txd_i = 4'h0;
  logic       tx_clk_o;
  logic [1:0] mlt3_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string tag = "R2";

  fe_sym_enc #(.SEED(SEED)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_i), .loopback_i(loopback_i),
    .tx_en_i(tx_en_i), .tx_er_i(tx_er_i), .txd_i(txd_i),
    .tx_clk_o(tx_clk_o), .mlt3_o(mlt3_o)
  );

  always #2 clk_i = ~clk_i;

  // R5 table, kept separately from the design
  function automatic logic [4:0] tb_code(input logic [3:0] d);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[d];
  endfunction

  // R10 level coding
  function automatic logic [1:0] tb_lvl(input logic [1:0] s);
    case (s)
      2'd1:    return 2'b01;
      2'd3:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // reference model: locked-edge count, bit schedule, scrambler, MLT3, framing
  int          n = 0;
  logic        ring [16];
  logic [10:0] mlf = SEED;
  logic [1:0]  mst = 2'd0;
  int          fst = 0;  // 0 idle, 1 K, 2 data, 3 R

  always @(posedge clk_i) begin
    logic       b, k;
    logic [4:0] g;
    logic [1:0] exp_o;
    logic       exp_c;
    #1;
    cyc++;
    if (!rst_ni || !lock_i) begin
      n = 0; mlf = SEED; mst = 2'd0; fst = 0;
      for (int i = 0; i < 16; i++) ring[i] = 1'b1;
    end else begin
      n++;
      b = ring[n % 16];
      ring[n % 16] = 1'b1;
      k = mlf[10] ^ mlf[8];               // R9
      mlf = {mlf[9:0], k};
      if (b ^ k) mst = mst + 2'd1;         // R10
      if (n % 5 == 0) begin                // R1 sampling edge
        g = 5'b11111;                      // R3
        case (fst)
          0: if (tx_en_i) begin g = 5'b11000; fst = 1; end            // R4 J
          1: begin g = 5'b10001; fst = 2; end                         // R4 K
          2: if (!tx_en_i) begin g = 5'b01101; fst = 3; end           // R7 T
             else if (tx_er_i) g = 5'b00100;                          // R6
             else g = tb_code(txd_i);                                 // R5
          default: begin g = 5'b00111; fst = 0; end                   // R7 R
        endcase
        for (int i = 0; i < 5; i++) ring[(n + 8 + i) % 16] = g[4-i];  // R8
      end
    end
    exp_o = loopback_i ? 2'b00 : tb_lvl(mst);                         // R11
    exp_c = (n >= 1) && (n % 5 < 2);
    if (!done) begin
      chk(mlt3_o === exp_o, tag, int'(mlt3_o), int'(exp_o));
      chk(tx_clk_o === exp_c, "R1", int'(tx_clk_o), int'(exp_c));
    end
  end

  task automatic nib(input logic en, input logic er, input logic [3:0] d);
    @(negedge clk_i);
    while (!(lock_i && n > 0 && n % 5 == 0)) @(negedge clk_i);
    tx_en_i = en; tx_er_i = er; txd_i = d;
  endtask

  task automatic frame(input int len, input int er_mod);
    nib(1'b1, 1'b0, 4'h5);
    nib(1'b1, 1'b1, 4'h5);   // R4: error inside the K nibble is not sent
    for (int i = 0; i < len; i++)
      nib(1'b1, (er_mod > 0) && ($urandom % er_mod == 0), 4'($urandom));
    nib(1'b0, 1'b0, 4'h0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4711));
    tag = "R2";
    repeat (4) @(negedge clk_i);
    chk(mlt3_o === 2'b00 && tx_clk_o === 1'b0, "R2 reset", int'({tx_clk_o, mlt3_o}), 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    lock_i = 1'b1;
    tag = "R3 R9 R10 idle";
    repeat (60) @(negedge clk_i);

    tag = "R4 R5 R8 frame";
    nib(1'b1, 1'b0, 4'h5);
    nib(1'b1, 1'b0, 4'h5);
    for (int i = 0; i < 16; i++) nib(1'b1, 1'b0, 4'(i));
    nib(1'b0, 1'b0, 4'h0);
    repeat (4) nib(1'b0, 1'b0, 4'h0);

    tag = "R6 error";
    nib(1'b1, 1'b0, 4'h5);
    nib(1'b1, 1'b0, 4'h5);
    nib(1'b1, 1'b1, 4'hA);
    nib(1'b1, 1'b0, 4'h3);
    nib(1'b0, 1'b1, 4'h0);   // error without enable is idle
    repeat (3) nib(1'b0, 1'b0, 4'h0);

    tag = "R7 back-to-back";
    nib(1'b1, 1'b0, 4'h0);
    nib(1'b1, 1'b0, 4'h0);
    nib(1'b1, 1'b0, 4'hF);
    nib(1'b0, 1'b0, 4'h0);   // T
    nib(1'b1, 1'b0, 4'h7);   // R, nibble ignored
    nib(1'b1, 1'b0, 4'h7);   // J
    nib(1'b1, 1'b0, 4'h7);
    nib(1'b0, 1'b0, 4'h0);   // K, then T
    repeat (4) nib(1'b0, 1'b0, 4'h0);

    tag = "R11 loopback";
    nib(1'b1, 1'b0, 4'h5);
    @(negedge clk_i) loopback_i = 1'b1;
    for (int i = 0; i < 6; i++) nib(1'b1, 1'b0, 4'(i * 3));
    @(negedge clk_i) loopback_i = 1'b0;
    frame(5, 0);

    tag = "R2 relock";
    nib(1'b1, 1'b0, 4'h5);
    nib(1'b1, 1'b0, 4'h5);
    nib(1'b1, 1'b0, 4'hC);
    repeat (3) @(negedge clk_i);
    lock_i = 1'b0;
    repeat (13) @(negedge clk_i);
    lock_i = 1'b1;
    nib(1'b1, 1'b0, 4'h2);   // enable still high: new frame from J
    nib(1'b1, 1'b0, 4'h2);
    nib(1'b0, 1'b0, 4'h0);
    repeat (4) nib(1'b0, 1'b0, 4'h0);

    tag = "R4 R5 R6 R7 random";
    for (int f = 0; f < 40; f++) begin
      if ($urandom % 8 == 0) @(negedge clk_i) loopback_i = 1'b1;
      frame(int'($urandom % 20), 12);
      loopback_i = 1'b0;
      repeat (int'($urandom % 3)) nib(1'b0, 1'($urandom), 4'($urandom));
    end
    repeat (30) @(negedge clk_i);
    finish_run();
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule